// File: doc/BRIEF.md
# Configurable SPI Master Channel

This block is one SPI master channel controlled by a single configuration word. It moves words of 4 up to `DATA_W` bits over two data lines, most significant bit first. Each line has its own transmit enable. A select bit chooses which line is sampled on receive. The chip-select level is set by software from a force bit and a polarity bit, so it never toggles by itself. The serial clock comes from a fixed divider of the system clock.

Software, or a DMA engine using the two request lines, writes a word into a transmit holding register and collects the result from a receive holding register. In the modes that transmit, loading the transmit register starts a transfer. In receive-only mode, enabling the channel or reading the receive register starts the next transfer. A back-to-back option lets transfers run one after another without waiting for each received word to be read. The serial clock idles low. Receive data is sampled on the rising edge and transmit data changes on the falling edge. Each clock phase lasts `DIV` system clocks.

Top module: `spi_chan_master`

## Requirements
- R1: Configuration bits [14:10] hold the word-length code. Code c sends max(c,3)+1 bits, so codes 0 to 2 give 4 bits and code 7 gives 8 bits. A result above `DATA_W` is limited to `DATA_W` bits. The number of rising serial-clock edges in a word equals this length.
- R2: Bits go out most significant first, and only the low word-length bits of the transmit register are sent. The received word is right-aligned, with zeros above it.
- R3: Configuration bits [9:8] select the mode: 0 is full-duplex, 1 is receive-only, 2 is transmit-only, and 3 behaves as full-duplex. Transmit-only leaves the receive register and its full flag unchanged. Receive-only drives neither data line.
- R4: Bit 4 controls line 0 and bit 5 controls line 1. A value of 0 drives that line's output enable during a transfer. A value of 1 never drives it. Neither line is driven while the channel is idle.
- R5: Bit 3 selects the receive line: 0 samples line 0 and 1 samples line 1.
- R6: After reset the configuration is 0x0028. This gives a 4-bit word, full-duplex, line 0 driving, line 1 not driving, receive on line 1, both DMA enables off, back-to-back off, and chip-select low.
- R7: The chip-select output equals force bit 0 XOR polarity bit 1, and it changes only after a configuration write.
- R8: In full-duplex and transmit-only modes, a transfer starts once the transmit register has been loaded, provided the channel is enabled.
- R9: In receive-only mode, a transfer starts when the channel enable rises and again each time a full receive register is read. Otherwise no transfer starts.
- R10: With back-to-back off (bit 2 = 0), no transfer starts while the receive register holds an unread word.
- R11: With back-to-back on, a loaded transmit word starts even while the received word is unread, and the newer received word replaces the older one.
- R12: The read request equals enable AND bit 6 AND receive-register-full. It drops in the cycle after a read.
- R13: The write request equals enable AND bit 7 AND transmit-register-empty. It drops in the cycle after a load.
- R14: Both request lines are low while the channel is disabled. The serial clock is low when idle, and each of its phases lasts `DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15 | Configuration word |
| tx_we | input | 1 | Transmit holding register load strobe |
| tx_wdata | input | DATA_W | Transmit word |
| rx_re | input | 1 | Receive holding register read strobe |
| rx_rdata | output | DATA_W | Receive holding register contents |
| dma_rd_req | output | 1 | DMA read request |
| dma_wr_req | output | 1 | DMA write request |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip-select level |
| d0_out | output | 1 | Data line 0 output value |
| d0_oe | output | 1 | Data line 0 output enable |
| d1_out | output | 1 | Data line 1 output value |
| d1_oe | output | 1 | Data line 1 output enable |
| d0_in | input | 1 | Data line 0 input |
| d1_in | input | 1 | Data line 1 input |

## Verification
The checker examines, on every cycle, the properties that depend only on the current state. These are: the request lines stay quiet while the channel is disabled, a request drops after its register is accessed, the lines are undriven and the serial clock is low when idle, the chip-select holds steady between configuration writes, and no transfer starts while an unread word blocks it. The bench scenarios cover the facts that need the serial data to be followed. These are: bit order and masking across a sweep of word-length codes, which line is sampled, the start rules of each mode, back-to-back overwrite, and the limiting of the word-length code.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

   typedef enum logic [1:0] {
      MODE_DUPLEX = 2'd0,
      MODE_RXONLY = 2'd1,
      MODE_TXONLY = 2'd2,
      MODE_SPARE  = 2'd3
   } xfer_mode_e;

   // Field order is fixed: bit 14 down to bit 0
   typedef struct packed {
      logic [4:0] wlen;
      xfer_mode_e mode;
      logic       dma_wr_en;
      logic       dma_rd_en;
      logic       tx_off1;
      logic       tx_off0;
      logic       in_sel;
      logic       b2b;
      logic       cs_pol;
      logic       cs_force;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);
   localparam logic [CFG_W-1:0] CFG_RESET = 15'h0028;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (DIV < 1) begin : g_bad
         $error("spi_clk_div: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == CW'(DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
   parameter int DATA_W = 16,
   localparam int LW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic [LW-1:0]     len_m1,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              rx_bit,
   output logic              busy,
   output logic              sclk,
   output logic              tx_bit,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [LW-1:0]     cnt_q;
   logic [LW-1:0]     len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sclk  <= 1'b0;
         done  <= 1'b0;
         tx_sh <= '0;
         rx_sh <= '0;
         cnt_q <= '0;
         len_q <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            sclk  <= 1'b0;
            tx_sh <= tx_word;
            rx_sh <= '0;
            cnt_q <= len_m1;
            len_q <= len_m1;
         end else if (busy && tick) begin
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sh <= {rx_sh[DATA_W-2:0], rx_bit};
            end else begin
               sclk  <= 1'b0;
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               if (cnt_q == '0) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
      end
   end

   assign tx_bit  = busy ? tx_sh[len_q] : 1'b0;
   assign rx_word = rx_sh;

endmodule

// File: rtl/spi_req_gen.sv
module spi_req_gen (
   input  logic en,
   input  logic rd_en,
   input  logic wr_en,
   input  logic rx_full,
   input  logic tx_full,
   output logic rd_req,
   output logic wr_req
);

   assign rd_req = en && rd_en && rx_full;
   assign wr_req = en && wr_en && !tx_full;

endmodule

// File: rtl/spi_chan_master.sv
module spi_chan_master
   import spi_chan_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DIV    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              cfg_we,
   input  logic [14:0]       cfg_wdata,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              rx_re,
   output logic [DATA_W-1:0] rx_rdata,
   output logic              dma_rd_req,
   output logic              dma_wr_req,
   output logic              spi_sclk,
   output logic              spi_cs,
   output logic              d0_out,
   output logic              d0_oe,
   output logic              d1_out,
   output logic              d1_oe,
   input  logic              d0_in,
   input  logic              d1_in
);

   localparam int LW = $clog2(DATA_W);

   generate
      if (DATA_W < 4 || DATA_W > 32) begin : g_bad_width
         $error("spi_chan_master: DATA_W must lie in 4..32");
      end
      if (CFG_W != 15) begin : g_bad_cfg
         $error("spi_chan_master: configuration word must be 15 bits");
      end
   endgenerate

   chan_cfg_t         cfg_q;
   logic [DATA_W-1:0] tx_hold;
   logic [DATA_W-1:0] rx_hold;
   logic              tx_full;
   logic              rx_full;
   logic              rx_go;
   logic              en_q;
   logic              busy;
   logic              done;
   logic              tick;
   logic              tx_bit;
   logic              rx_bit;
   logic [DATA_W-1:0] rx_word;
   logic [4:0]        code_eff;
   logic [LW-1:0]     len_m1;
   logic              tx_mode;
   logic              rx_capture;
   logic              start;

   // Effective length: reserved short codes map to 4 bits, long ones clamp
   always_comb begin
      code_eff = cfg_q.wlen;
      if (code_eff < 5'd3) begin
         code_eff = 5'd3;
      end
      if (int'(code_eff) > DATA_W - 1) begin
         code_eff = 5'(DATA_W - 1);
      end
   end
   assign len_m1 = code_eff[LW-1:0];

   assign tx_mode    = (cfg_q.mode != MODE_RXONLY);
   assign rx_capture = done && (cfg_q.mode != MODE_TXONLY);
   assign start      = chan_en && !busy && !done
                       && (cfg_q.b2b || !rx_full)
                       && (tx_mode ? tx_full : rx_go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= chan_cfg_t'(CFG_RESET);
         tx_hold <= '0;
         rx_hold <= '0;
         tx_full <= 1'b0;
         rx_full <= 1'b0;
         rx_go   <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         en_q <= chan_en;
         if (cfg_we) begin
            cfg_q <= chan_cfg_t'(cfg_wdata);
         end
         if (tx_we) begin
            tx_hold <= tx_wdata;
            tx_full <= 1'b1;
         end else if (start && tx_mode) begin
            tx_full <= 1'b0;
         end
         if (rx_capture) begin
            rx_hold <= rx_word;
            rx_full <= 1'b1;
         end else if (rx_re) begin
            rx_full <= 1'b0;
         end
         if ((chan_en && !en_q) || (rx_re && rx_full)) begin
            rx_go <= 1'b1;
         end else if (start) begin
            rx_go <= 1'b0;
         end
      end
   end

   spi_clk_div #(
      .DIV (DIV)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   assign rx_bit = cfg_q.in_sel ? d1_in : d0_in;

   spi_shift_eng #(
      .DATA_W (DATA_W)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .tick    (tick),
      .len_m1  (len_m1),
      .tx_word (tx_hold),
      .rx_bit  (rx_bit),
      .busy    (busy),
      .sclk    (spi_sclk),
      .tx_bit  (tx_bit),
      .done    (done),
      .rx_word (rx_word)
   );

   spi_req_gen u_req (
      .en      (chan_en),
      .rd_en   (cfg_q.dma_rd_en),
      .wr_en   (cfg_q.dma_wr_en),
      .rx_full (rx_full),
      .tx_full (tx_full),
      .rd_req  (dma_rd_req),
      .wr_req  (dma_wr_req)
   );

   assign d0_oe    = busy && tx_mode && !cfg_q.tx_off0;
   assign d1_oe    = busy && tx_mode && !cfg_q.tx_off1;
   assign d0_out   = d0_oe && tx_bit;
   assign d1_out   = d1_oe && tx_bit;
   assign spi_cs   = cfg_q.cs_force ^ cfg_q.cs_pol;
   assign rx_rdata = rx_hold;

endmodule

// File: rtl/spi_chan_checker.sv
module spi_chan_checker (
   input logic clk,
   input logic rst_n,
   input logic chan_en,
   input logic cfg_we,
   input logic tx_we,
   input logic rx_re,
   input logic b2b,
   input logic rx_full,
   input logic busy,
   input logic done,
   input logic dma_rd_req,
   input logic dma_wr_req,
   input logic d0_oe,
   input logic d1_oe,
   input logic spi_sclk,
   input logic spi_cs
);

   p_req_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> (!dma_rd_req && !dma_wr_req));

   p_wr_req_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
      tx_we |=> !dma_wr_req);

   p_rd_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_re && !done) |=> !dma_rd_req);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!d0_oe && !d1_oe && !spi_sclk));

   p_cs_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(spi_cs));

   p_hold_unread_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!b2b && rx_full && !busy) |=> !busy);

endmodule

bind spi_chan_master spi_chan_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_en    (chan_en),
   .cfg_we     (cfg_we),
   .tx_we      (tx_we),
   .rx_re      (rx_re),
   .b2b        (cfg_q.b2b),
   .rx_full    (rx_full),
   .busy       (busy),
   .done       (done),
   .dma_rd_req (dma_rd_req),
   .dma_wr_req (dma_wr_req),
   .d0_oe      (d0_oe),
   .d1_oe      (d1_oe),
   .spi_sclk   (spi_sclk),
   .spi_cs     (spi_cs)
);

// File: tb/test_spi_chan_master.sv
module test_spi_chan_master;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int DIV        = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chan_en = 1'b0;
   logic              cfg_we = 1'b0;
   logic [14:0]       cfg_wdata = '0;
   logic              tx_we = 1'b0;
   logic [DATA_W-1:0] tx_wdata = '0;
   logic              rx_re = 1'b0;
   logic [DATA_W-1:0] rx_rdata;
   logic              dma_rd_req, dma_wr_req;
   logic              spi_sclk, spi_cs;
   logic              d0_out, d0_oe, d1_out, d1_oe;
   logic              d0_in, d1_in;

   int                n_checks = 0;
   int                n_fail = 0;
   int                rise_cnt = 0;
   int                cur_len = 4;
   logic              loopback = 1'b0;
   logic [DATA_W-1:0] slave_sh = '0;
   logic [DATA_W-1:0] mosi0_sh = '0;
   logic [DATA_W-1:0] mosi1_sh = '0;
   logic              saw_oe0 = 1'b0;
   logic              saw_oe1 = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_chan_master #(
      .DATA_W (DATA_W),
      .DIV    (DIV)
   ) i_spi_chan_master (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_en    (chan_en),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .tx_we      (tx_we),
      .tx_wdata   (tx_wdata),
      .rx_re      (rx_re),
      .rx_rdata   (rx_rdata),
      .dma_rd_req (dma_rd_req),
      .dma_wr_req (dma_wr_req),
      .spi_sclk   (spi_sclk),
      .spi_cs     (spi_cs),
      .d0_out     (d0_out),
      .d0_oe      (d0_oe),
      .d1_out     (d1_out),
      .d1_oe      (d1_oe),
      .d0_in      (d0_in),
      .d1_in      (d1_in)
   );

   // Bench-side slave: presents its MSB first, advances on falling sclk
   assign d0_in = slave_sh[cur_len-1];
   assign d1_in = loopback ? d1_out : ~slave_sh[cur_len-1];

   always @(negedge spi_sclk) slave_sh <= slave_sh << 1;

   always @(posedge spi_sclk) begin
      rise_cnt <= rise_cnt + 1;
      mosi0_sh <= {mosi0_sh[DATA_W-2:0], d0_out};
      mosi1_sh <= {mosi1_sh[DATA_W-2:0], d1_out};
      if (d0_oe) saw_oe0 <= 1'b1;
      if (d1_oe) saw_oe1 <= 1'b1;
   end

   function automatic logic [14:0] mk_cfg(int wl, int md, bit dwr, bit drd,
                                          bit off1, bit off0, bit insel,
                                          bit b2b, bit pol, bit frc);
      return {5'(wl), 2'(md), dwr, drd, off1, off0, insel, b2b, pol, frc};
   endfunction

   function automatic int elen(int code);
      int c;
      c = (code < 3) ? 3 : code;
      if (c > DATA_W - 1) c = DATA_W - 1;
      return c + 1;
   endfunction

   function automatic logic [DATA_W-1:0] lmask(int len);
      return (len >= DATA_W) ? '1 : DATA_W'((1 << len) - 1);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [14:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_tx(input logic [DATA_W-1:0] w);
      @(negedge clk);
      tx_we = 1'b1;
      tx_wdata = w;
      @(negedge clk);
      tx_we = 1'b0;
   endtask

   task automatic read_rx(output logic [DATA_W-1:0] w);
      @(negedge clk);
      w = rx_rdata;
      rx_re = 1'b1;
      @(negedge clk);
      rx_re = 1'b0;
   endtask

   task automatic wait_rises(input int target);
      for (int k = 0; k < 4000 && rise_cnt < target; k++) @(negedge clk);
      chk(rise_cnt >= target, "R8 transfer did not run", rise_cnt, target);
      repeat (2*DIV + 4) @(negedge clk);
   endtask

   task automatic prep(input logic [DATA_W-1:0] slv, input int len);
      cur_len  = len;
      slave_sh = slv;
      mosi0_sh = '0;
      mosi1_sh = '0;
      saw_oe0  = 1'b0;
      saw_oe1  = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] rd, rd2, tw, sw;
      int base, len;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk(spi_cs == 1'b0, "R6 cs after reset", spi_cs, 0);
      chk(spi_sclk == 1'b0, "R14 sclk idle", spi_sclk, 0);
      chk(!d0_oe && !d1_oe, "R4 idle undriven", {d1_oe, d0_oe}, 0);
      chk(!dma_rd_req && !dma_wr_req, "R14 requests while disabled",
          {dma_rd_req, dma_wr_req}, 0);

      // Reset configuration: 4-bit, line 0 drives, receive on line 1 (inverted slave)
      chan_en = 1'b1;
      @(negedge clk);
      chk(!dma_wr_req, "R6 write request enable off at reset", dma_wr_req, 0);
      prep(16'h000B, 4);
      base = rise_cnt;
      load_tx(16'hFFF6);
      wait_rises(base + 4);
      chk(rise_cnt == base + 4, "R1 reset length 4", rise_cnt - base, 4);
      chk(mosi0_sh[3:0] == 4'h6, "R2 low bits sent on line 0", mosi0_sh[3:0], 4'h6);
      chk(saw_oe0 && !saw_oe1, "R6 line enables at reset", {saw_oe1, saw_oe0}, 1);
      chk(rx_rdata == 16'h0004, "R5 reset samples line 1", rx_rdata, 16'h0004);
      chk(!dma_rd_req, "R6 read request enable off at reset", dma_rd_req, 0);
      read_rx(rd);

      // Full-duplex sweep: transmit on line 1, receive on line 0
      wr_cfg(mk_cfg(3, 0, 1, 1, 0, 1, 0, 0, 0, 0));
      for (int code = 0; code < 16; code++) begin
         wr_cfg(mk_cfg(code, 0, 1, 1, 0, 1, 0, 0, 0, 0));
         len = elen(code);
         tw  = DATA_W'(16'h9E37 * (code + 1) + 16'h0135);
         sw  = DATA_W'(16'hA5C3 ^ (code * 16'h1111));
         prep(sw, len);
         base = rise_cnt;
         chk(dma_wr_req, "R13 write request when empty", dma_wr_req, 1);
         load_tx(tw);
         wait_rises(base + len);
         chk(rise_cnt == base + len, "R1 clock count", rise_cnt - base, len);
         chk((mosi1_sh & lmask(len)) == (tw & lmask(len)), "R2 transmitted bits",
             mosi1_sh & lmask(len), tw & lmask(len));
         chk(!saw_oe0 && saw_oe1, "R4 only line 1 driven", {saw_oe1, saw_oe0}, 2);
         chk(rx_rdata == (sw & lmask(len)), "R2 received right-aligned",
             rx_rdata, sw & lmask(len));
         chk(dma_rd_req, "R12 read request when full", dma_rd_req, 1);
         read_rx(rd);
         chk(!dma_rd_req, "R12 read request drops", dma_rd_req, 0);
      end

      // Clamp of an over-long code
      wr_cfg(mk_cfg(31, 0, 1, 1, 0, 1, 0, 0, 0, 0));
      prep(16'h8001, 16);
      base = rise_cnt;
      load_tx(16'hC35A);
      wait_rises(base + 16);
      chk(rise_cnt == base + 16, "R1 clamped to DATA_W", rise_cnt - base, 16);
      chk(rx_rdata == 16'h8001, "R1 clamped receive", rx_rdata, 16'h8001);
      read_rx(rd);

      // Loopback on line 1 with mode code 3 (full-duplex behaviour)
      loopback = 1'b1;
      for (int code = 4; code < 16; code += 5) begin
         wr_cfg(mk_cfg(code, 3, 0, 1, 0, 1, 1, 0, 0, 0));
         len = elen(code);
         tw  = DATA_W'(16'h5AF0 + code * 16'h0321);
         prep('0, len);
         base = rise_cnt;
         load_tx(tw);
         wait_rises(base + len);
         chk(rx_rdata == (tw & lmask(len)), "R5 line 1 selected, R3 code 3",
             rx_rdata, tw & lmask(len));
         read_rx(rd);
      end

      // Transmit-only: receive register untouched
      wr_cfg(mk_cfg(7, 2, 0, 1, 0, 1, 1, 0, 0, 0));
      prep('0, 8);
      base = rise_cnt;
      load_tx(16'h00A7);
      wait_rises(base + 8);
      chk(mosi1_sh[7:0] == 8'hA7, "R3 transmit-only data", mosi1_sh[7:0], 8'hA7);
      chk(!dma_rd_req, "R3 transmit-only leaves receive empty", dma_rd_req, 0);
      loopback = 1'b0;

      // Back-to-back off: second word waits for the read
      wr_cfg(mk_cfg(7, 0, 1, 1, 0, 1, 0, 0, 0, 0));
      prep(16'h003C, 8);
      base = rise_cnt;
      load_tx(16'h0011);
      wait_rises(base + 8);
      load_tx(16'h0022);
      repeat (60) @(negedge clk);
      chk(rise_cnt == base + 8, "R10 blocked while unread", rise_cnt - base, 8);
      chk(!dma_wr_req, "R13 write request low while full", dma_wr_req, 0);
      prep(16'h00C5, 8);
      read_rx(rd);
      chk(rd == 16'h003C, "R10 first word", rd, 16'h003C);
      wait_rises(base + 16);
      chk(rx_rdata == 16'h00C5, "R10 second word after read", rx_rdata, 16'h00C5);
      read_rx(rd);

      // Back-to-back on: loopback, two words without reading
      loopback = 1'b1;
      wr_cfg(mk_cfg(7, 0, 1, 1, 0, 1, 1, 1, 0, 0));
      prep('0, 8);
      base = rise_cnt;
      load_tx(16'h0081);
      repeat (4) @(negedge clk);
      load_tx(16'h007E);
      wait_rises(base + 16);
      repeat (40) @(negedge clk);
      chk(rise_cnt == base + 16, "R11 both words ran", rise_cnt - base, 16);
      chk(rx_rdata == 16'h007E, "R11 newer word replaces older", rx_rdata, 16'h007E);
      loopback = 1'b0;

      // Request gating with a full receive register
      chan_en = 1'b0;
      @(negedge clk);
      chk(!dma_rd_req && !dma_wr_req, "R14 requests low when disabled",
          {dma_rd_req, dma_wr_req}, 0);
      chan_en = 1'b1;
      @(negedge clk);
      chk(dma_rd_req && dma_wr_req, "R12 R13 requests return", {dma_rd_req, dma_wr_req}, 3);
      wr_cfg(mk_cfg(7, 0, 0, 0, 0, 1, 1, 1, 0, 0));
      chk(!dma_rd_req && !dma_wr_req, "R12 R13 enable bits off",
          {dma_rd_req, dma_wr_req}, 0);
      read_rx(rd);

      // Receive-only: starts on enable, then on each read
      chan_en = 1'b0;
      wr_cfg(mk_cfg(5, 1, 0, 1, 0, 0, 0, 0, 0, 0));
      prep(16'h002D, 6);
      base = rise_cnt;
      @(negedge clk);
      chan_en = 1'b1;
      wait_rises(base + 6);
      chk(rx_rdata == 16'h002D, "R9 receive on enable", rx_rdata, 16'h002D);
      chk(!saw_oe0 && !saw_oe1, "R3 receive-only drives nothing", {saw_oe1, saw_oe0}, 0);
      repeat (60) @(negedge clk);
      chk(rise_cnt == base + 6, "R9 no restart while unread", rise_cnt - base, 6);
      prep(16'h0013, 6);
      read_rx(rd2);
      wait_rises(base + 12);
      chk(rx_rdata == 16'h0013, "R9 restart on read", rx_rdata, 16'h0013);
      read_rx(rd2);
      chan_en = 1'b0;
      repeat (30) @(negedge clk);

      // Chip-select sweep
      for (int f = 0; f < 2; f++) begin
         for (int p = 0; p < 2; p++) begin
            wr_cfg(mk_cfg(7, 0, 0, 0, 1, 0, 1, 0, p[0], f[0]));
            repeat (3) @(negedge clk);
            chk(spi_cs == (f[0] ^ p[0]), "R7 chip-select level", spi_cs, f ^ p);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule